// File: doc/BRIEF.md
# Selectable Random-Bit Whitener

This block cleans up a raw stream of random bits before they are used as key or seed material. Raw bits arrive one per cycle, with a valid strobe. A single mode input picks one of two correctors. In pair mode, a von Neumann corrector removes bias from the stream and emits single bits. In hash mode, a compressor folds every sixteen raw bits into one eight-bit word.

A producer can present a bit on every clock cycle; the block never stalls it. Results appear on one registered output port with a one-cycle strobe. A change of mode discards whatever half-collected pair or group is held, so a new mode always starts from a clean boundary.

Top module: `trng_whitener`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: With `mode_hash` = 0 (pair mode), the accepted bits form consecutive non-overlapping pairs. A pair whose first bit is 1 and second bit is 0 emits 1, and a pair (0 then 1) emits 0. The emitted bit is on `out_data[0]` and `out_data[7:1]` is 0. The strobe comes on the cycle after the second bit of the pair is accepted.
- R3: In pair mode, the pairs (0,0) and (1,1) emit nothing. Pairing restarts after every pair, whether that pair emitted a bit or was dropped.
- R4: With `mode_hash` = 1 (hash mode), accepted bits are collected in groups of 16. The first bit of a group is the most significant bit of the upper byte A1, and the last 8 bits form A2, with the last accepted bit as its LSB. The output is A1 XOR (A1 rotated left by one) XOR A2.
- R5: In hash mode, exactly one 8-bit word is emitted per 16 accepted bits, on the cycle after the 16th bit. The group 0110111011110100, with its first bit leftmost, gives 01000110.
- R6: `out_valid` is high for a single cycle per result. Cycles with `in_valid` = 0 are ignored and do not break a pair or a group.
- R7: A change of `mode_hash` discards any partial pair or group, whether or not a bit is accepted in that cycle. A bit accepted in the cycle of the change is the first bit in the new mode.
- R8: Bits accepted on every consecutive cycle are all processed, with no stall and no lost bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hash | input | 1 | 0 = pair corrector, 1 = 16-to-8 hash |
| in_valid | input | 1 | Raw bit present this cycle |
| in_bit | input | 1 | Raw random bit |
| out_valid | output | 1 | One-cycle strobe for a result |
| out_data | output | 8 | Result: bit 0 in pair mode, full byte in hash mode |

## Verification
Every result is due exactly one clock cycle after the raw bit that completes it. In pair mode that bit is the second of the pair; in hash mode it is the sixteenth of the group. When the driver feeds such a bit, it stamps the expected item with the cycle count of the next edge. The monitor samples on the falling edge and compares both the value and the cycle count. Any strobe the model did not predict is a failure, and so is any expected item left over at the end. This covers dropped pairs, flushed partial state and gaps in the input.

// File: rtl/trng_whitener.sv
module trng_whitener #(
  parameter int GROUP_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_hash,
  input  logic                   in_valid,
  input  logic                   in_bit,
  output logic                   out_valid,
  output logic [GROUP_W/2-1:0]   out_data
);
  localparam int HALF = GROUP_W / 2;
  localparam int CW   = $clog2(GROUP_W);
  localparam logic [CW-1:0] LAST = CW'(GROUP_W - 1);

  logic               mode_q;
  logic [CW-1:0]      cnt;
  logic [GROUP_W-2:0] sh;

  logic               flush;
  logic [CW-1:0]      cnt_eff;
  logic [GROUP_W-1:0] grp;
  logic [HALF-1:0]    a1, a2, hash;

  assign flush   = mode_hash != mode_q;
  assign cnt_eff = flush ? '0 : cnt;
  assign grp     = {sh, in_bit};
  assign a1      = grp[GROUP_W-1:HALF];
  assign a2      = grp[HALF-1:0];
  assign hash    = a1 ^ {a1[HALF-2:0], a1[HALF-1]} ^ a2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      cnt       <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      mode_q    <= mode_hash;
      out_valid <= 1'b0;
      if (in_valid) begin
        sh <= {sh[GROUP_W-3:0], in_bit};
        if (mode_hash) begin
          if (cnt_eff == LAST) begin
            cnt       <= '0;
            out_valid <= 1'b1;
            out_data  <= hash;
          end else begin
            cnt <= CW'(cnt_eff + 1'b1);
          end
        end else if (!cnt_eff[0]) begin
          cnt <= CW'(1);
        end else begin
          cnt <= '0;
          if (sh[0] != in_bit) begin
            out_valid <= 1'b1;
            out_data  <= {{(HALF-1){1'b0}}, sh[0]};
          end
        end
      end else if (flush) begin
        cnt <= '0;
      end
    end
  end

  // R6: a result needs at least two accepted bits, so strobes never touch
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8: every result is caused by a bit accepted on the previous cycle
  a_r8_from_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2: the closing bit of an emitting pair is the opposite of the emitted bit
  a_r2_pair_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode_q) |-> ($past(in_bit) != out_data[0]));

  // R2: the upper bits stay zero in pair mode
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode_q) |-> (out_data[HALF-1:1] == '0));

  // R7: a mode change leaves no partial state that could complete next cycle
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hash != $past(mode_hash)) |=> !out_valid);

  // R1: output quiet on the first cycle out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_trng_whitener.sv
module tb_trng_whitener;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_hash = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid;
  logic [7:0] out_data;

  trng_whitener dut (
    .clk(clk), .rst_n(rst_n), .mode_hash(mode_hash),
    .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] q_d[$];
  int         q_due[$];
  string      q_tag[$];

  logic        m_mode = 1'b0;
  int          m_cnt = 0;
  logic        m_first = 1'b0;
  logic [15:0] m_grp = '0;

  function automatic logic [7:0] hash16(input logic [15:0] g);
    logic [7:0] u;
    logic [7:0] l;
    u = g[15:8];
    l = g[7:0];
    return u ^ {u[6:0], u[7]} ^ l;
  endfunction

  task automatic push(input logic [7:0] d, input string tag);
    q_d.push_back(d);
    q_due.push_back(cyc + 1);
    q_tag.push_back(tag);
  endtask

  task automatic model(input logic b);
    if (m_mode) begin
      m_grp = {m_grp[14:0], b};
      m_cnt++;
      if (m_cnt == 16) begin
        push(hash16(m_grp), "R4 R5");
        m_cnt = 0;
      end
    end else if (m_cnt == 0) begin
      m_first = b;
      m_cnt = 1;
    end else begin
      m_cnt = 0;
      if (m_first != b) push({7'b0, m_first}, "R2");
    end
  endtask

  task automatic drive(input logic m, input logic v, input logic b);
    @(negedge clk);
    if (m != m_mode) begin
      m_mode = m;
      m_cnt = 0;
    end
    mode_hash = m;
    in_valid = v;
    in_bit = b;
    if (v) model(b);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) drive(1'b1, 1'b1, w[i]);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (q_d.size() == 0) begin
        failures++;
        $display("FAIL R3 or R7: unexpected strobe data=%h expected no output (cycle %0d)",
                 out_data, cyc);
      end else begin
        logic [7:0] d;
        int due;
        string tag;
        d = q_d.pop_front();
        due = q_due.pop_front();
        tag = q_tag.pop_front();
        if (out_data !== d || cyc != due) begin
          failures++;
          $display("FAIL %s: data=%h cycle=%0d expected data=%h cycle=%0d",
                   tag, out_data, cyc, d, due);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (out_valid !== 1'b0 || out_data !== 8'h00) begin
      failures++;
      $display("FAIL R1: valid=%b data=%h expected valid=0 data=00", out_valid, out_data);
    end
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 first cycle out of reset
    if (out_valid !== 1'b0 || out_data !== 8'h00) begin
      failures++;
      $display("FAIL R1: valid=%b data=%h expected valid=0 data=00", out_valid, out_data);
    end

    // R2 R3 R8: back-to-back pairs 10 01 00 11 10
    drive(0,1,1); drive(0,1,0); drive(0,1,0); drive(0,1,1);
    drive(0,1,0); drive(0,1,0); drive(0,1,1); drive(0,1,1);
    drive(0,1,1); drive(0,1,0);
    // R6: gaps inside a pair
    drive(0,1,0); drive(0,0,1); drive(0,0,0); drive(0,1,1);
    // R7: partial pair, then hash mode starting with the worked example (R5)
    drive(0,1,1);
    send_word(16'b0110111011110100);
    // R4 R8: further groups, one with gaps (R6)
    lf = 16'hACE1;
    for (int g = 0; g < 3; g++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]} ^ 16'h3C5A;
      if (g == 1) begin
        for (int i = 15; i >= 0; i--) begin
          drive(1,1,lf[i]);
          if (i % 5 == 0) drive(1,0,1'b1);
        end
      end else begin
        send_word(lf);
      end
    end
    // R4: all ones gives FF
    send_word(16'hFFFF);
    // R7: partial group of 7, then pair mode
    for (int i = 0; i < 7; i++) drive(1,1,i[0]);
    drive(0,1,0); drive(0,1,1); drive(0,1,1); drive(0,1,0);
    // R7: change with no bit accepted, then back
    drive(0,1,1); drive(1,0,0); drive(0,1,0); drive(0,1,0);
    drive(0,1,1); drive(0,1,0);
    repeat (4) drive(0,0,0);

    checks++;  // R3 R7: nothing expected remains
    if (q_d.size() != 0) begin
      failures++;
      $display("FAIL R3 R7: %0d results missing, expected 0", q_d.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule